// File: doc/BRIEF.md
# Multiplexed Digit Readout with Leading-Zero Blanking

This block takes an eight-digit BCD count and places one digit at a time on a shared 4-bit output bus. An external scanner supplies a column index over a valid/ready request stream. For each accepted request the block returns one column record on a valid/ready output stream. Each record carries the digit code, a blank flag, a symbol-select flag and the column index. Column 0 is the most significant digit and the last column is the least significant.

Leading zeros are suppressed while the columns are scanned in order. Each request for column 0 starts a new scan and re-arms the suppression. From then on, every zero column is flagged blank until the first nonzero digit has been scanned. An overflow flag is set by a carry out of the top decade and cleared when a new measurement starts. While the flag is set, column 0 is presented as a greater-than symbol instead of a digit. A downstream stage turns the record into display levels.

Back-pressure rules: `scan_ready` is high whenever the output register is empty or is being drained in the same cycle. A request is taken on any clock where `scan_valid` and `scan_ready` are both high. A record with `out_valid` high and `out_ready` low stays unchanged until it is taken.

Top module: `digit_readout`

## Requirements
- R1: After reset, `out_valid` is low, `scan_ready` is high and the overflow flag is clear, so a following column-0 record has `out_sym` low.
- R2: An accepted request for column k gives one record on the next clock. Its `out_col` is k and its `out_digit` is the count nibble at bits [4*(7-k)+3 : 4*(7-k)], so column 0 is bits [31:28].
- R3: In a scan that starts at column 0, each zero column before the first nonzero column has `out_blank` high and `out_digit` equal to 0.
- R4: Column 7, the least significant, never has `out_blank` high, even when the count is all zeros.
- R5: Zero columns after the first nonzero column of a scan are not blanked. A new request for column 0 re-arms suppression, even when the previous scan was abandoned part way.
- R6: `ovf_carry` sets the overflow flag and `meas_start` clears it. When both are high in the same cycle, the flag is set.
- R7: While the flag is set, a column-0 record has `out_sym` high and `out_blank` low, and its `out_digit` is don't-care. Records for other columns always have `out_sym` low.
- R8: `scan_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, all record outputs hold their values.
- R9: The symbol decision uses the flag value held at the clock that accepts the column-0 request. A carry that arrives in that same cycle affects only later scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_bcd | input | 32 | Eight BCD digits, most significant in the top nibble |
| ovf_carry | input | 1 | Carry pulse out of the top decade |
| meas_start | input | 1 | Start-of-measurement pulse; clears overflow |
| scan_valid | input | 1 | Column request valid |
| scan_ready | output | 1 | Column request can be accepted |
| scan_col | input | 3 | Requested column, 0 = most significant |
| out_valid | output | 1 | Column record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_digit | output | 4 | Digit code for the column |
| out_blank | output | 1 | Column is dark (suppressed zero) |
| out_sym | output | 1 | Show the overflow symbol instead of the digit |
| out_col | output | 3 | Column index of the record |

## Verification
The assertions check, on every cycle, these properties of the records: a blanked record carries a zero digit; the least significant column is never dark; the symbol appears only on column 0 and never together with blanking; and a stalled record stays stable. They also check how the overflow flag reacts to carry and start pulses. Whether a particular zero is a leading zero depends on the digits scanned before it, so only the bench's scenarios can show it. The same holds for re-arming after an abandoned scan and for the cycle in which a carry first reaches the symbol. The bench shows these with a reference model and with directed count patterns.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;

  typedef struct packed {
    bcd_t digit;
    logic blank;
    logic sym;
  } col_rec_t;
endpackage

// File: rtl/rdo_ovf_flag.sv
module rdo_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic carry,
  input  logic start,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (carry) flag <= 1'b1;
    else if (start) flag <= 1'b0;
  end
endmodule

// File: rtl/rdo_digit_sel.sv
module rdo_digit_sel
  import readout_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] count,
  input  logic [IDX_W-1:0]              idx,
  output bcd_t                          digit
);
  bcd_t lanes [NUM_DIGITS];

  // Column 0 sits in the top nibble.
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_lane
    assign lanes[g] = count[(NUM_DIGITS-1-g)*DIGIT_W +: DIGIT_W];
  end

  always_comb begin
    digit = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (idx == IDX_W'(i)) digit = lanes[i];
    end
  end
endmodule

// File: rtl/rdo_blank_track.sv
module rdo_blank_track
  import readout_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IDX_W-1:0] idx,
  input  bcd_t             digit,
  input  logic             ovf,
  output col_rec_t         rec
);
  localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(NUM_DIGITS - 1);

  logic lead_q;
  logic lead_in;
  logic is_zero;
  logic first_col;

  assign first_col = (idx == '0);
  assign lead_in   = first_col ? 1'b1 : lead_q;
  assign is_zero   = (digit == '0);

  always_comb begin
    rec.digit = digit;
    rec.sym   = first_col && ovf;
    rec.blank = !rec.sym && lead_in && is_zero && (idx != LAST_COL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lead_q <= 1'b1;
    else if (accept) lead_q <= lead_in && is_zero;
  end
endmodule

// File: rtl/digit_readout.sv
module digit_readout
  import readout_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] count_bcd,
  input  logic                          ovf_carry,
  input  logic                          meas_start,
  input  logic                          scan_valid,
  output logic                          scan_ready,
  input  logic [IDX_W-1:0]              scan_col,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DIGIT_W-1:0]            out_digit,
  output logic                          out_blank,
  output logic                          out_sym,
  output logic [IDX_W-1:0]              out_col
);
  logic     ovf_q;
  logic     accept;
  bcd_t     sel_digit;
  col_rec_t next_rec;
  col_rec_t rec_q;

  assign scan_ready = !out_valid || out_ready;
  assign accept     = scan_valid && scan_ready;

  rdo_ovf_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .carry (ovf_carry),
    .start (meas_start),
    .flag  (ovf_q)
  );

  rdo_digit_sel #(.NUM_DIGITS(NUM_DIGITS), .IDX_W(IDX_W)) u_sel (
    .count (count_bcd),
    .idx   (scan_col),
    .digit (sel_digit)
  );

  rdo_blank_track #(.NUM_DIGITS(NUM_DIGITS), .IDX_W(IDX_W)) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .idx    (scan_col),
    .digit  (sel_digit),
    .ovf    (ovf_q),
    .rec    (next_rec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rec_q     <= '0;
      out_col   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      rec_q     <= next_rec;
      out_col   <= scan_col;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_digit = rec_q.digit;
  assign out_blank = rec_q.blank;
  assign out_sym   = rec_q.sym;
endmodule

// File: rtl/digit_readout_chk.sv
module digit_readout_chk #(
  parameter int NUM_DIGITS = 8,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ovf_carry,
  input logic             meas_start,
  input logic             ovf_q,
  input logic             out_valid,
  input logic             out_ready,
  input logic [3:0]       out_digit,
  input logic             out_blank,
  input logic             out_sym,
  input logic [IDX_W-1:0] out_col
);
  localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(NUM_DIGITS - 1);

  AST_BLANK_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_blank |-> out_digit == 4'd0); // R3
  AST_LSD_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_col == LAST_COL |-> !out_blank); // R4
  AST_SYM_ON_MSD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sym |-> out_col == '0 && !out_blank); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_digit) && $stable(out_blank)
      && $stable(out_sym) && $stable(out_col)); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_carry |=> ovf_q); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start && !ovf_carry |=> !ovf_q); // R6
endmodule

bind digit_readout digit_readout_chk #(.NUM_DIGITS(NUM_DIGITS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ovf_carry  (ovf_carry),
  .meas_start (meas_start),
  .ovf_q      (ovf_q),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_digit  (out_digit),
  .out_blank  (out_blank),
  .out_sym    (out_sym),
  .out_col    (out_col)
);

// File: tb/test_digit_readout.sv
`timescale 1ns/1ps
module test_digit_readout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] count_bcd = '0;
  logic        ovf_carry = 1'b0, meas_start = 1'b0;
  logic        scan_valid = 1'b0, out_ready = 1'b1;
  logic [2:0]  scan_col = '0;
  logic        scan_ready, out_valid, out_blank, out_sym;
  logic [3:0]  out_digit;
  logic [2:0]  out_col;

  always #2.5 clk = ~clk;

  digit_readout i_digit_readout (
    .clk(clk), .rst_n(rst_n), .count_bcd(count_bcd), .ovf_carry(ovf_carry),
    .meas_start(meas_start), .scan_valid(scan_valid), .scan_ready(scan_ready),
    .scan_col(scan_col), .out_valid(out_valid), .out_ready(out_ready),
    .out_digit(out_digit), .out_blank(out_blank), .out_sym(out_sym), .out_col(out_col)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural reference model
  bit e_valid, e_blank, e_sym, m_ovf, m_lead;
  int e_digit, e_col;
  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; m_ovf = 0; m_lead = 1; e_blank = 0; e_sym = 0; e_digit = 0; e_col = 0;
    end else begin
      bit acc, lead;
      int d, k;
      acc = scan_valid && (!e_valid || out_ready);
      if (acc) begin
        k = int'(scan_col);
        d = int'((count_bcd >> (4 * (7 - k))) & 32'hF);
        lead = (k == 0) ? 1'b1 : m_lead;
        e_sym = (k == 0) && m_ovf;
        e_blank = !e_sym && lead && (d == 0) && (k != 7);
        m_lead = lead && (d == 0);
        e_digit = d; e_col = k; e_valid = 1;
      end else if (out_ready) e_valid = 0;
      if (ovf_carry) m_ovf = 1;
      else if (meas_start) m_ovf = 0;
    end
  end

  bit [7:0] bmask, smask;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    if (rst_n) begin
      check(out_valid == e_valid, "R8 out_valid", out_valid, e_valid);
      check(scan_ready == (!e_valid || out_ready), "R8 scan_ready", scan_ready, !e_valid || out_ready);
      if (e_valid && out_valid) begin
        check(int'(out_col) == e_col, "R2 column", out_col, e_col);
        if (!e_sym) check(int'(out_digit) == e_digit, "R2 digit", out_digit, e_digit);
        check(out_blank == e_blank, e_col == 7 ? "R4 blank" : "R3 blank", out_blank, e_blank);
        check(out_sym == e_sym, "R7 symbol", out_sym, e_sym);
        bmask[out_col] = out_blank;
        smask[out_col] = out_sym;
      end
    end
  endtask

  task automatic scan_all(input logic [31:0] c);
    bmask = '0; smask = '0; out_ready = 1; count_bcd = c;
    for (int k = 0; k < 8; k++) begin
      scan_valid = 1; scan_col = 3'(k); tick();
    end
    scan_valid = 0; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1 valid after reset", out_valid, 0);
    check(scan_ready == 1, "R1 ready after reset", scan_ready, 1);
    scan_all(32'h0001_2000);
    check(smask == 8'h00, "R1 no symbol after reset", smask, 0);
    check(bmask == 8'h07, "R3 leading zeros dark", bmask, 8'h07);
    check(bmask[7:5] == 3'b000, "R5 trailing zeros lit", bmask[7:5], 0);
    scan_all(32'h0000_0000);
    check(bmask == 8'h7F, "R4 all-zero keeps last column", bmask, 8'h7F);
    scan_all(32'h9000_0000);
    check(bmask == 8'h00, "R5 nonzero msd", bmask, 0);
    // R6/R7: carry pulse sets the flag
    ovf_carry = 1; tick(); ovf_carry = 0;
    scan_all(32'h0000_0005);
    check(smask == 8'h01, "R7 symbol on column 0", smask, 1);
    check(bmask == 8'h7E, "R7 symbol column not dark", bmask, 8'h7E);
    meas_start = 1; tick(); meas_start = 0;
    scan_all(32'h0000_0005);
    check(smask == 8'h00, "R6 start clears flag", smask, 0);
    ovf_carry = 1; meas_start = 1; tick(); ovf_carry = 0; meas_start = 0;
    scan_all(32'h1234_5678);
    check(smask == 8'h01, "R6 carry wins over start", smask, 1);
    meas_start = 1; tick(); meas_start = 0;
    // R9: carry in the cycle column 0 is accepted affects the next scan only
    bmask = '0; smask = '0; count_bcd = 32'h0000_0001;
    scan_valid = 1; scan_col = 0; ovf_carry = 1; tick(); ovf_carry = 0;
    for (int k = 1; k < 8; k++) begin scan_col = 3'(k); tick(); end
    scan_valid = 0; tick();
    check(smask == 8'h00, "R9 same-cycle carry not shown", smask, 0);
    scan_all(32'h0000_0001);
    check(smask == 8'h01, "R9 carry shown on next scan", smask, 1);
    meas_start = 1; tick(); meas_start = 0;
    // R5: abandoned scan then restart re-arms suppression
    count_bcd = 32'h0050_0000;
    for (int k = 0; k < 4; k++) begin scan_valid = 1; scan_col = 3'(k); tick(); end
    scan_valid = 0; tick();
    scan_all(32'h0000_0030);
    check(bmask == 8'h3F, "R5 restart re-arms", bmask, 8'h3F);
    // R8: stall holds the record
    count_bcd = 32'h7000_0000; out_ready = 0; scan_valid = 1; scan_col = 0; tick();
    scan_col = 1; tick(); tick();
    check(out_col == 3'd0 && out_digit == 4'd7, "R8 stalled record held", out_col, 0);
    out_ready = 1; tick(); scan_valid = 0; tick();
    // Random traffic compared against the model every clock
    begin
      int nxt = 0;
      for (int i = 0; i < 2000; i++) begin
        bit acc;
        if (nxt == 0) count_bcd = $urandom() & 32'h0F0F_0F0F;
        scan_valid = ($urandom() % 4) != 0;
        out_ready  = ($urandom() % 3) != 0;
        ovf_carry  = ($urandom() % 50) == 0;
        meas_start = ($urandom() % 40) == 0;
        scan_col = 3'(nxt);
        #0.5;
        acc = scan_valid && scan_ready;
        tick();
        if (acc) nxt = (nxt + 1) % 8;
      end
    end
    scan_valid = 0; out_ready = 1; ovf_carry = 0; meas_start = 0; tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule